// File: doc/BRIEF.md
# 8-bit Accumulator Arithmetic Unit with Flag Register

This block is the arithmetic unit for an 8-bit accumulator machine. A single shared adder serves five operations: add-with-carry, subtract-with-carry, compare, and increment or decrement of an index value. The carry input of the arithmetic always comes from the block's own four-bit flag register. That register holds negative, overflow, zero and carry, and it is updated on a clock edge when the caller strobes an operation.

There is no subtract that ignores carry. On subtract, carry means "no borrow pending", so a caller that wants a plain difference first loads carry with 1 through the flag write port. Compare uses the same subtract path with carry forced to 1. It reports only through the flags and lowers the result write strobe. Increment and decrement touch only the negative and zero flags, so a loop counter can be stepped without disturbing a carry chain.

The result and the candidate next flags are combinational from the operands and the registered flags. The register file, instruction sequencing and decimal arithmetic belong to the surrounding machine.

Top module: `acc_alu8`

## Requirements
- R1: Operation code 0 (add) gives res_o = opnd_a + opnd_b + C modulo 256, with next C = 1 exactly when that sum exceeds 255. C is the carry bit of the flag register.
- R2: Operation code 1 (subtract) gives res_o = opnd_a - opnd_b - (1 - C) modulo 256. Next C is 1 when no borrow occurred, that is when opnd_a >= opnd_b + (1 - C), and 0 otherwise.
- R3: For codes 0 and 1, next V is 1 exactly when the signed two's-complement result of the operation lies outside -128..127.
- R4: Operation code 2 (compare) sets next C to 1 when opnd_a >= opnd_b as unsigned values, whatever the registered C. It keeps V and drives res_we_o low. res_o shows opnd_a - opnd_b modulo 256.
- R5: Operation codes 3 (increment) and 4 (decrement) give res_o = opnd_a + 1 and opnd_a - 1 modulo 256 respectively, and keep C and V unchanged.
- R6: For codes 0 to 4, next Z is 1 exactly when res_o is 0x00, and next N equals res_o bit 7. res_we_o is 1 for codes 0, 1, 3 and 4.
- R7: The flags are packed as bit 3 N, bit 2 V, bit 1 Z, bit 0 C on flags_wr_val, flags_nxt_o and flags_q_o. On a rising clock edge with exec_en high, the register takes flags_nxt_o. Otherwise, with flags_wr_en high, it takes flags_wr_val. Otherwise it holds. exec_en wins when both are high.
- R8: While rst_n is low, and until the second rising edge after rst_n goes high, the flag register reads 0000.
- R9: Codes 5, 6 and 7 are not operations. For them res_o = opnd_a, res_we_o = 0, and flags_nxt_o equals flags_q_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Commit the selected operation's flags on this edge |
| op_sel | input | 3 | Operation code (0 add, 1 subtract, 2 compare, 3 increment, 4 decrement) |
| opnd_a | input | 8 | First operand (accumulator, compare register or index value) |
| opnd_b | input | 8 | Second operand |
| flags_wr_en | input | 1 | Load flags_wr_val into the flag register |
| flags_wr_val | input | 4 | Flag value to load, packed N V Z C |
| res_o | output | 8 | Operation result |
| res_we_o | output | 1 | The result is meant to be written back |
| flags_nxt_o | output | 4 | Flags the operation would produce, packed N V Z C |
| flags_q_o | output | 4 | Registered flags, packed N V Z C |

## Verification
The assertions assume that op_sel, the operands and the two enables are settled before each rising edge. They also assume that the registered carry they read is the carry the arithmetic actually used, which holds because the carry input comes from inside the block. The bench changes inputs only at falling edges for clocked scenarios. During the exhaustive operand sweeps it keeps both enables low, so combinational inputs can move freely without any edge committing state. Each sweep first loads the flag register through the write port, which puts every operation under a known carry and overflow value.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_cur,
  output logic [W-1:0] add_x,
  output logic [W-1:0] add_y,
  output logic         add_ci
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    add_x  = opnd_a;
    add_y  = '0;
    add_ci = 1'b0;
    case (op_sel)
      OP_ADD: begin add_y = opnd_b;  add_ci = carry_cur; end
      OP_SUB: begin add_y = ~opnd_b; add_ci = carry_cur; end
      OP_CMP: begin add_y = ~opnd_b; add_ci = 1'b1;      end
      OP_INC: begin add_y = ONE;     add_ci = 1'b0;      end
      OP_DEC: begin add_y = '1;      add_ci = 1'b0;      end
      default: begin add_y = '0;     add_ci = 1'b0;      end
    endcase
  end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         add_ci,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W:0] full;

  assign full = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  // signed overflow: like-signed inputs giving an opposite-signed sum
  assign ovf  = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

endmodule

// File: rtl/acc_alu_flagnext.sv
module acc_alu_flagnext
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      sum,
  input  logic              cout,
  input  logic              ovf,
  input  logic [FLAG_W-1:0] flags_cur,
  output logic [FLAG_W-1:0] flags_nxt,
  output logic              res_we
);

  alu_flags_t cur, nxt;
  logic       is_zero;

  assign cur     = alu_flags_t'(flags_cur);
  assign is_zero = (sum == '0);

  always_comb begin
    nxt    = cur;
    res_we = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        nxt    = '{neg: sum[W-1], ovf: ovf, zero: is_zero, carry: cout};
        res_we = 1'b1;
      end
      OP_CMP: begin
        nxt    = '{neg: sum[W-1], ovf: cur.ovf, zero: is_zero, carry: cout};
        res_we = 1'b0;
      end
      OP_INC, OP_DEC: begin
        nxt    = '{neg: sum[W-1], ovf: cur.ovf, zero: is_zero, carry: cur.carry};
        res_we = 1'b1;
      end
      default: begin
        nxt    = cur;
        res_we = 1'b0;
      end
    endcase
  end

  assign flags_nxt = nxt;

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [FLAG_W-1:0] flags_nxt,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_val,
  output logic [FLAG_W-1:0] flags_q
);

  logic              load_en;
  logic [FLAG_W-1:0] flags_d;

  assign load_en = exec_en | wr_en;

  always_comb begin
    flags_d = flags_q;
    if (exec_en)    flags_d = flags_nxt;
    else if (wr_en) flags_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (load_en) flags_q <= flags_d;
  end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic              flags_wr_en,
  input  logic [FLAG_W-1:0] flags_wr_val,
  output logic [W-1:0]      res_o,
  output logic              res_we_o,
  output logic [FLAG_W-1:0] flags_nxt_o,
  output logic [FLAG_W-1:0] flags_q_o
);

  logic              rst_sync_n;
  logic [W-1:0]      add_x, add_y, sum;
  logic              add_ci, cout, ovf;
  logic [FLAG_W-1:0] flags_q, flags_nxt;
  alu_flags_t        flags_view;

  assign flags_view = alu_flags_t'(flags_q);

  acc_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  acc_alu_opsel #(.W(W)) u_opsel (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_cur(flags_view.carry),
    .add_x(add_x), .add_y(add_y), .add_ci(add_ci)
  );

  acc_alu_adder #(.W(W)) u_add (
    .add_x(add_x), .add_y(add_y), .add_ci(add_ci),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  acc_alu_flagnext #(.W(W)) u_fnext (
    .op_sel(op_sel), .sum(sum), .cout(cout), .ovf(ovf),
    .flags_cur(flags_q), .flags_nxt(flags_nxt), .res_we(res_we_o)
  );

  acc_alu_flagreg u_freg (
    .clk(clk), .rst_n(rst_sync_n), .exec_en(exec_en),
    .flags_nxt(flags_nxt), .wr_en(flags_wr_en), .wr_val(flags_wr_val),
    .flags_q(flags_q)
  );

  assign res_o       = sum;
  assign flags_nxt_o = flags_nxt;
  assign flags_q_o   = flags_q;

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_en,
  input logic [2:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         wr_en,
  input logic [3:0]   wr_val,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic [3:0]   nxt,
  input logic [3:0]   q
);

  // R1: carry-out and sum together equal the full unsigned addition
  a_r1_add_total: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0) |-> ({nxt[0], res} == ((W+1)'(opnd_a) + (W+1)'(opnd_b) + (W+1)'(q[0]))));

  // R2: carry after subtract means no borrow
  a_r2_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1) |-> (nxt[0] == ((W+1)'(opnd_a) >= (W+1)'(opnd_b) + (W+1)'(!q[0]))));

  // R4: compare carry ignores the registered carry; no write-back
  a_r4_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |-> ((nxt[0] == (opnd_a >= opnd_b)) && !res_we));

  // R4: committed compare leaves overflow alone
  a_r4_cmp_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_sel == 3'd2) |=> (q[2] == $past(q[2])));

  // R5: committed step leaves carry and overflow alone
  a_r5_step_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_sel == 3'd3 || op_sel == 3'd4)) |=> (q[0] == $past(q[0]) && q[2] == $past(q[2])));

  // R6: a result cannot be both zero and negative
  a_r6_nz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= 3'd4) |-> !(nxt[3] && nxt[1]));

  // R7: register loading priority
  a_r7_exec_load: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> (q == $past(nxt)));
  a_r7_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && wr_en) |=> (q == $past(wr_val)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !wr_en) |=> $stable(q));

  // R9: unused codes are transparent and quiet
  a_r9_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 3'd4) |-> (!res_we && nxt == q && res == opnd_a));

endmodule

bind acc_alu8 acc_alu8_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .exec_en(exec_en), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_en(flags_wr_en), .wr_val(flags_wr_val),
  .res(res_o), .res_we(res_we_o), .nxt(flags_nxt_o), .q(flags_q_o)
);

// File: tb/acc_alu8_tb_top.sv
module acc_alu8_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_en;
  logic [2:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic       flags_wr_en;
  logic [3:0] flags_wr_val;
  logic [7:0] res_o;
  logic       res_we_o;
  logic [3:0] flags_nxt_o, flags_q_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu8 dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_wr_en(flags_wr_en),
    .flags_wr_val(flags_wr_val), .res_o(res_o), .res_we_o(res_we_o),
    .flags_nxt_o(flags_nxt_o), .flags_q_o(flags_q_o)
  );

  // returns {result[12:5], write strobe[4], flags N V Z C [3:0]}
  function automatic logic [12:0] ref_model(input logic [2:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [3:0] f);
    int u, s, sa, sb, cin;
    logic [7:0] r;
    logic we, n, v, z, c;
    sa = int'($signed(a)); sb = int'($signed(b)); cin = int'(f[0]);
    v = f[2]; c = f[0]; we = 1'b1; r = a;
    case (op)
      3'd0: begin u = int'(a) + int'(b) + cin; r = u[7:0]; c = (u > 255);
                  s = sa + sb + cin; v = (s > 127) || (s < -128); end
      3'd1: begin u = int'(a) - int'(b) - (1 - cin); r = u[7:0]; c = (u >= 0);
                  s = sa - sb - (1 - cin); v = (s > 127) || (s < -128); end
      3'd2: begin u = int'(a) - int'(b); r = u[7:0]; c = (a >= b); we = 1'b0; end
      3'd3: r = a + 8'd1;
      3'd4: r = a - 8'd1;
      default: begin r = a; we = 1'b0; end
    endcase
    n = r[7]; z = (r == 8'h00);
    if (op > 3'd4) return {r, we, f};
    return {r, we, n, v, z, c};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_flags(input logic [3:0] val);
    @(negedge clk);
    flags_wr_en = 1'b1; flags_wr_val = val;
    @(posedge clk); #1;
    flags_wr_en = 1'b0;
  endtask

  task automatic commit(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    exec_en = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    @(posedge clk); #1;
    exec_en = 1'b0;
  endtask

  task automatic comb_case(input string req, input logic [2:0] op, input logic [7:0] a,
                           input logic [7:0] b, input logic [12:0] exp);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    #1;
    chk(req, "result/we/flags", {3'b0, res_o, res_we_o, flags_nxt_o}, {3'b0, exp});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; exec_en = 1'b0; flags_wr_en = 1'b0; flags_wr_val = 4'h0;
    op_sel = 3'd0; opnd_a = 8'h00; opnd_b = 8'h00;
    repeat (3) @(posedge clk);
    #1 chk("R8", "flags in reset", {12'h0, flags_q_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    // release takes two edges; a write before then must not land
    flags_wr_en = 1'b1; flags_wr_val = 4'hF;
    @(posedge clk); #1;
    chk("R8", "flags one edge after release", {12'h0, flags_q_o}, 16'h0000);
    flags_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R8", "flags after release", {12'h0, flags_q_o}, 16'h0000);
  endtask

  task automatic t_sweep(input string req, input logic [2:0] op, input logic cin);
    int mism = 0;
    logic [12:0] first_act = '0, first_exp = '0, e;
    logic [3:0] f;
    f = {1'b0, ~cin, 1'b0, cin};
    load_flags(f);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        op_sel = op; opnd_a = 8'(a); opnd_b = 8'(b);
        #1;
        e = ref_model(op, 8'(a), 8'(b), f);
        if ({res_o, res_we_o, flags_nxt_o} !== e) begin
          if (mism == 0) begin first_act = {res_o, res_we_o, flags_nxt_o}; first_exp = e; end
          mism++;
        end
      end
    end
    chk(req, $sformatf("sweep op %0d cin %0d first mismatch", op, cin),
        {3'b0, first_act}, {3'b0, first_exp});
    chk(req, $sformatf("sweep op %0d cin %0d mismatch count", op, cin), 16'(mism), 16'h0000);
  endtask

  task automatic t_subtract;
    load_flags(4'b0001);
    comb_case("R2", 3'd1, 8'h05, 8'h03, {8'h02, 1'b1, 4'b0001});
    comb_case("R2", 3'd1, 8'h03, 8'h05, {8'hFE, 1'b1, 4'b1000});
    load_flags(4'b0000);
    comb_case("R2", 3'd1, 8'h05, 8'h03, {8'h01, 1'b1, 4'b0001});
    comb_case("R2 R6", 3'd1, 8'h00, 8'h00, {8'hFF, 1'b1, 4'b1000});
    comb_case("R3", 3'd1, 8'h80, 8'h01, {8'h7E, 1'b1, 4'b0101});
  endtask

  task automatic t_add;
    load_flags(4'b0000);
    comb_case("R1 R3", 3'd0, 8'h50, 8'h50, {8'hA0, 1'b1, 4'b1100});
    comb_case("R1 R6", 3'd0, 8'hFF, 8'h01, {8'h00, 1'b1, 4'b0011});
    commit(3'd0, 8'hFF, 8'h01);
    chk("R7", "flags after add commit", {12'h0, flags_q_o}, 16'h0003);
  endtask

  task automatic t_compare;
    load_flags(4'b0100);
    comb_case("R4", 3'd2, 8'h42, 8'h42, {8'h00, 1'b0, 4'b0111});
    comb_case("R4", 3'd2, 8'h10, 8'h20, {8'hF0, 1'b0, 4'b1100});
    commit(3'd2, 8'h42, 8'h42);
    chk("R4", "flags after compare commit", {12'h0, flags_q_o}, 16'h0007);
  endtask

  task automatic t_step;
    load_flags(4'b0101);
    comb_case("R5", 3'd4, 8'h00, 8'h00, {8'hFF, 1'b1, 4'b1101});
    commit(3'd4, 8'h00, 8'h00);
    chk("R5", "carry and overflow kept after decrement", {12'h0, flags_q_o}, 16'h000D);
    commit(3'd3, 8'hFF, 8'h00);
    chk("R5 R6", "flags after increment wrap", {12'h0, flags_q_o}, 16'h0007);
  endtask

  task automatic t_register;
    load_flags(4'b0111);
    @(negedge clk);
    exec_en = 1'b1; flags_wr_en = 1'b1; flags_wr_val = 4'hF;
    op_sel = 3'd0; opnd_a = 8'h01; opnd_b = 8'h01;
    @(posedge clk); #1;
    exec_en = 1'b0; flags_wr_en = 1'b0;
    chk("R7", "operation wins over write", {12'h0, flags_q_o}, 16'h0000);
    load_flags(4'b1010);
    op_sel = 3'd1; opnd_a = 8'h00; opnd_b = 8'h55;
    repeat (3) @(posedge clk);
    #1 chk("R7", "flags held when idle", {12'h0, flags_q_o}, 16'h000A);
  endtask

  task automatic t_unused;
    load_flags(4'b1001);
    comb_case("R9", 3'd6, 8'h9C, 8'h12, {8'h9C, 1'b0, 4'b1001});
    commit(3'd7, 8'h00, 8'h00);
    chk("R9", "flags after unused code commit", {12'h0, flags_q_o}, 16'h0009);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_subtract();
    t_compare();
    t_step();
    t_register();
    t_unused();
    for (int c = 0; c < 2; c++) begin
      t_sweep("R1 R3 R6", 3'd0, c[0]);
      t_sweep("R2 R3 R6", 3'd1, c[0]);
      t_sweep("R4 R6",    3'd2, c[0]);
      t_sweep("R5 R6",    3'd3, c[0]);
      t_sweep("R5 R6",    3'd4, c[0]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule